// File: doc/BRIEF.md
# Privileged Opcode Trap Filter

This block sits beside a processor's data bus and looks at every byte the processor fetches as an instruction opcode. When memory protection is active, it compares that byte against two sets of dangerous instructions. The first set is never allowed while protection is on. The second set is refused only to user-level code. When a fetched opcode is not allowed, the block raises a trap request in the same cycle. That request is meant to be combined into the processor's abort input.

A set-status-bits instruction can switch interrupts off in disguise. When user code fetches that instruction, the filter arms itself and checks the operand byte of the next program fetch. If that byte's interrupt-disable bit is set, the filter traps on the operand cycle.

Every trap also records the offending opcode in a sticky cause register. The kernel reads this register and clears it with a one-cycle clear strobe.

Top module: `priv_op_filter`

## Requirements
- R1: After reset, `trap_o` is 0, `cause_vld_o` is 0 and `cause_o` is 8'h00.
- R2: With `mode_i` = 2'd0 (real), `trap_o` never goes high for any byte or fetch type.
- R3: Opcodes 8'h02, 8'hDB, 8'h42 and 8'hFB raise `trap_o` when fetched with `op_fetch_i` high while `mode_i` is 2'd1 (user), 2'd2 (kernel) or 2'd3 (interrupt).
- R4: Opcodes 8'h5C, 8'hDC, 8'h22, 8'h40, 8'h6B and 8'h78 raise `trap_o` on an opcode fetch in user mode only. In kernel and interrupt modes they do not trap, and no other opcode traps.
- R5: Suppose an opcode fetch of 8'hE2 happens in user mode. If the next operand fetch in user mode carries a byte with bit 2 set, `trap_o` goes high in that operand cycle. Idle cycles between the two fetches do not cancel the check.
- R6: An 8'hE2 operand with bit 2 clear does not trap. An 8'hE2 fetched in any mode other than user does not arm the check. An armed check is spent by the first operand fetch.
- R7: A byte that arrives while neither `op_fetch_i` nor `arg_fetch_i` is high never traps. An operand fetch with no armed check never traps.
- R8: `trap_o` is combinational and aligned to the offending fetch cycle, so it lasts only as long as that fetch strobe.
- R9: The first trap sets `cause_vld_o` one clock later and stores the opcode in `cause_o`; for the disguised case this is 8'hE2. Later traps leave the stored value unchanged while `cause_vld_o` is high.
- R10: `cause_clr_i` empties the cause register on the next clock. If a trap arrives in the same cycle as the clear, the new trap's opcode is captured and `cause_vld_o` stays high.
- R11: Any opcode fetch that is not a user-mode 8'hE2 disarms a pending operand check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_byte_i | input | 8 | Data bus byte |
| op_fetch_i | input | 1 | Current cycle fetches an opcode |
| arg_fetch_i | input | 1 | Current cycle fetches an operand byte |
| mode_i | input | 2 | Protection level: 0 real, 1 user, 2 kernel, 3 interrupt |
| cause_clr_i | input | 1 | Kernel clear strobe for the cause register |
| trap_o | output | 1 | Trap request for the abort line |
| cause_o | output | 8 | Stored offending opcode |
| cause_vld_o | output | 1 | Cause register holds a value |

## Verification
A new trap and the kernel's clear strobe can land in the same clock. In that case the capture must win over the clear. The bench arms the disguised-disable check and then drives its operand byte while `cause_clr_i` is high. One clock later it expects `cause_vld_o` high and `cause_o` equal to 8'hE2. The bench also runs separate cases with a clear alone and with a trap alone, so the result of the combined cycle can be told apart from either effect on its own.

// File: rtl/opf_pkg.sv
package opf_pkg;
    localparam int OP_W     = 8;
    localparam int N_ALWAYS = 4;
    localparam int N_USER   = 6;
    localparam int SEI_BIT  = 2;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_USER   = 2'd1,
        MODE_KERNEL = 2'd2,
        MODE_INTR   = 2'd3
    } prot_mode_e;

    localparam logic [OP_W-1:0] ALWAYS_OPS [N_ALWAYS] = '{8'h02, 8'hDB, 8'h42, 8'hFB};
    localparam logic [OP_W-1:0] USER_OPS   [N_USER]   = '{8'h5C, 8'hDC, 8'h22, 8'h40, 8'h6B, 8'h78};
    localparam logic [OP_W-1:0] SEP_OP = 8'hE2;

    typedef struct packed {
        logic always_hit;
        logic user_hit;
        logic sep_hit;
    } op_class_t;

    typedef struct packed {
        logic armed;
    } arm_state_t;

    typedef struct packed {
        logic            vld;
        logic [OP_W-1:0] code;
    } cause_state_t;
endpackage

// File: rtl/opf_classifier.sv
module opf_classifier
    import opf_pkg::*;
(
    input  logic [OP_W-1:0] byte_i,
    output op_class_t       class_o
);
    logic [N_ALWAYS-1:0] always_match;
    logic [N_USER-1:0]   user_match;

    for (genvar i = 0; i < N_ALWAYS; i++) begin : g_always
        assign always_match[i] = (byte_i == ALWAYS_OPS[i]);
    end

    for (genvar j = 0; j < N_USER; j++) begin : g_user
        assign user_match[j] = (byte_i == USER_OPS[j]);
    end

    always_comb begin
        class_o            = '0;
        class_o.always_hit = |always_match;
        class_o.user_hit   = |user_match;
        class_o.sep_hit    = (byte_i == SEP_OP);
    end
endmodule

// File: rtl/opf_sep_tracker.sv
module opf_sep_tracker
    import opf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic op_fetch_i,
    input  logic arg_fetch_i,
    input  logic sep_user_i,
    output logic armed_o
);
    arm_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (op_fetch_i) begin
            state_d.armed = sep_user_i;
        end else if (arg_fetch_i) begin
            state_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign armed_o = state_q.armed;

    a_r11_cancel_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_fetch_i && !sep_user_i) |=> !armed_o);

    a_r6_spent_by_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arg_fetch_i && !op_fetch_i) |=> !armed_o);
endmodule

// File: rtl/opf_cause_latch.sv
module opf_cause_latch
    import opf_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            trap_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            clr_i,
    output logic            vld_o,
    output logic [OP_W-1:0] code_o
);
    cause_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = '0;
        end
        if (trap_i && !state_d.vld) begin
            state_d.vld  = 1'b1;
            state_d.code = opcode_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign vld_o  = state_q.vld;
    assign code_o = state_q.code;

    a_r9_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_o && !clr_i) |=> (vld_o && $stable(code_o)));

    a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !trap_i) |=> !vld_o);

    a_r10_trap_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && trap_i) |=> vld_o);
endmodule

// File: rtl/priv_op_filter.sv
module priv_op_filter
    import opf_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [OP_W-1:0] bus_byte_i,
    input  logic            op_fetch_i,
    input  logic            arg_fetch_i,
    input  logic [1:0]      mode_i,
    input  logic            cause_clr_i,
    output logic            trap_o,
    output logic [OP_W-1:0] cause_o,
    output logic            cause_vld_o
);
    prot_mode_e      mode;
    op_class_t       cls;
    logic            armed;
    logic            is_user;
    logic            is_prot;
    logic            sep_user;
    logic            op_trap;
    logic            arg_trap;
    logic [OP_W-1:0] trap_code;

    assign mode = prot_mode_e'(mode_i);

    opf_classifier u_cls (
        .byte_i  (bus_byte_i),
        .class_o (cls)
    );

    always_comb begin
        is_user   = (mode == MODE_USER);
        is_prot   = (mode != MODE_REAL);
        sep_user  = op_fetch_i && is_user && cls.sep_hit;
        op_trap   = op_fetch_i && ((is_prot && cls.always_hit) || (is_user && cls.user_hit));
        arg_trap  = !op_fetch_i && arg_fetch_i && armed && is_user && bus_byte_i[SEI_BIT];
        trap_code = arg_trap ? SEP_OP : bus_byte_i;
    end

    opf_sep_tracker u_arm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_fetch_i  (op_fetch_i),
        .arg_fetch_i (arg_fetch_i),
        .sep_user_i  (sep_user),
        .armed_o     (armed)
    );

    assign trap_o = op_trap || arg_trap;

    opf_cause_latch u_cause (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trap_i   (trap_o),
        .opcode_i (trap_code),
        .clr_i    (cause_clr_i),
        .vld_o    (cause_vld_o),
        .code_o   (cause_o)
    );

    a_r2_real_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0) |-> !trap_o);

    a_r7_no_fetch_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!op_fetch_i && !arg_fetch_i) |-> !trap_o);

    a_r5_operand_trap_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && !op_fetch_i) |-> armed);

    a_r9_first_trap_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> cause_vld_o);
endmodule

// File: tb/priv_op_filter_bench.sv
module priv_op_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_byte = '0;
    logic       op_f = 1'b0;
    logic       arg_f = 1'b0;
    logic [1:0] mode = '0;
    logic       clr = 1'b0;
    logic       trap;
    logic [7:0] cause;
    logic       cause_vld;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    priv_op_filter u_priv_op_filter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_byte_i  (bus_byte),
        .op_fetch_i  (op_f),
        .arg_fetch_i (arg_f),
        .mode_i      (mode),
        .cause_clr_i (clr),
        .trap_o      (trap),
        .cause_o     (cause),
        .cause_vld_o (cause_vld)
    );

    // entry: {req[3:0], mode[1:0], op_fetch, arg_fetch, byte[7:0], expected trap}
    localparam int NV = 32;
    localparam logic [16:0] VEC [NV] = '{
        {4'd2,  2'd0, 1'b1, 1'b0, 8'h02, 1'b0},  // R2 real COP
        {4'd3,  2'd1, 1'b1, 1'b0, 8'h02, 1'b1},  // R3 user
        {4'd3,  2'd2, 1'b1, 1'b0, 8'hDB, 1'b1},  // R3 kernel
        {4'd3,  2'd3, 1'b1, 1'b0, 8'h42, 1'b1},  // R3 interrupt
        {4'd3,  2'd1, 1'b1, 1'b0, 8'hFB, 1'b1},  // R3
        {4'd2,  2'd0, 1'b1, 1'b0, 8'hFB, 1'b0},  // R2
        {4'd2,  2'd0, 1'b1, 1'b0, 8'h78, 1'b0},  // R2
        {4'd4,  2'd1, 1'b1, 1'b0, 8'h5C, 1'b1},  // R4
        {4'd4,  2'd2, 1'b1, 1'b0, 8'hDC, 1'b0},  // R4 kernel allowed
        {4'd4,  2'd1, 1'b1, 1'b0, 8'h22, 1'b1},  // R4
        {4'd4,  2'd3, 1'b1, 1'b0, 8'h40, 1'b0},  // R4 interrupt allowed
        {4'd4,  2'd1, 1'b1, 1'b0, 8'h6B, 1'b1},  // R4
        {4'd4,  2'd1, 1'b1, 1'b0, 8'h78, 1'b1},  // R4
        {4'd4,  2'd2, 1'b1, 1'b0, 8'h78, 1'b0},  // R4
        {4'd4,  2'd1, 1'b1, 1'b0, 8'hA9, 1'b0},  // R4 harmless opcode
        {4'd7,  2'd1, 1'b0, 1'b0, 8'h02, 1'b0},  // R7 no fetch
        {4'd7,  2'd1, 1'b0, 1'b1, 8'h04, 1'b0},  // R7 operand, not armed
        {4'd5,  2'd1, 1'b1, 1'b0, 8'hE2, 1'b0},  // R5 arm
        {4'd5,  2'd1, 1'b0, 1'b1, 8'h04, 1'b1},  // R5 disguised disable
        {4'd6,  2'd1, 1'b1, 1'b0, 8'hE2, 1'b0},  // R6 arm
        {4'd6,  2'd1, 1'b0, 1'b1, 8'hFB, 1'b0},  // R6 bit 2 clear
        {4'd6,  2'd2, 1'b1, 1'b0, 8'hE2, 1'b0},  // R6 kernel
        {4'd6,  2'd2, 1'b0, 1'b1, 8'h04, 1'b0},  // R6 kernel operand
        {4'd11, 2'd1, 1'b1, 1'b0, 8'hE2, 1'b0},  // R11 arm
        {4'd11, 2'd1, 1'b1, 1'b0, 8'hA9, 1'b0},  // R11 cancel
        {4'd11, 2'd1, 1'b0, 1'b1, 8'h04, 1'b0},  // R11 no trap
        {4'd5,  2'd1, 1'b1, 1'b0, 8'hE2, 1'b0},  // R5 arm
        {4'd7,  2'd1, 1'b0, 1'b0, 8'h04, 1'b0},  // R7 idle keeps arm
        {4'd5,  2'd1, 1'b0, 1'b1, 8'h04, 1'b1},  // R5 trap after idle
        {4'd6,  2'd1, 1'b0, 1'b1, 8'h04, 1'b0},  // R6 spent
        {4'd2,  2'd0, 1'b1, 1'b0, 8'hE2, 1'b0},  // R2 real SEP
        {4'd2,  2'd0, 1'b0, 1'b1, 8'h04, 1'b0}   // R2 real operand
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic o, input logic a,
                         input logic [7:0] b, input logic c);
        mode = m; op_f = o; arg_f = a; bus_byte = b; clr = c;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 trap", trap, 0);
        check("R1 cause_vld", cause_vld, 0);
        check("R1 cause", cause, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8:1], 1'b0);
            #1;
            checks++;
            if (trap != VEC[i][0]) begin
                fails++;
                $display("FAIL R%0d vector %0d: actual %0b expected %0b",
                         VEC[i][16:13], i, trap, VEC[i][0]);
            end
        end
        @(negedge clk);
        drive(2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
        #1;
        check("R9 first cause kept", cause, 8'h02);
        check("R9 cause valid", cause_vld, 1);

        // Reset again, then directed cases
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 cause_vld after reset", cause_vld, 0);
        check("R1 cause after reset", cause, 0);

        drive(2'd1, 1'b1, 1'b0, 8'hDB, 1'b0);
        #1 check("R3 user STP", trap, 1);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 8'hDB, 1'b0);
        #1 check("R8 pulse ends with fetch", trap, 0);
        check("R9 cause captured", cause, 8'hDB);
        check("R9 valid set", cause_vld, 1);

        @(negedge clk);
        drive(2'd1, 1'b1, 1'b0, 8'h6B, 1'b0);
        #1 check("R4 user RTL", trap, 1);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 8'h00, 1'b1);
        #1 check("R9 cause not overwritten", cause, 8'hDB);

        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
        #1 check("R10 clear empties valid", cause_vld, 0);
        check("R10 clear empties code", cause, 0);

        drive(2'd1, 1'b1, 1'b0, 8'hE2, 1'b0);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b1, 8'h04, 1'b1);
        #1 check("R5 operand trap with clear", trap, 1);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
        #1 check("R10 trap wins over clear", cause_vld, 1);
        check("R9 disguised cause code", cause, 8'hE2);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule